// File: doc/BRIEF.md
# Dual-Window Video Memory Bank Mapper

This block sits between an 8-bit processor bus with 16-bit addresses and a video memory that is larger than the processor can address. The processor sees an 8 KB window at 0xC000 to 0xDFFF. That window is split into two 4 KB halves. Each half takes its upper physical address bits from its own 8-bit bank register. The processor reaches the two bank registers at 0xFF00 and 0xFF01.

Window address bit 12 picks the register. When it is 0 the register at 0xFF00 supplies the bank. When it is 1 the register at 0xFF01 supplies it. The 20-bit physical address is the selected bank value placed above the low 12 offset bits. Software can therefore show two unrelated 4 KB regions of video memory at once, for example a tile map in one half and an attribute area in the other, and move either one with a single register write.

A window write drives the memory write strobe, the address and the data in the same cycle as the processor write. A window read drives the memory read strobe at once. The data, which a synchronous memory returns one cycle later, appears on the processor read bus in the following cycle. Register reads have the same one-cycle latency.

Top module: `vram_bank_mapper`

## Requirements
- R1: After a synchronous reset both bank registers read back 0x00, and no memory strobe is asserted while the processor bus is idle.
- R2: `mem_we` and `mem_re` are asserted only for processor accesses with an address in 0xC000..0xDFFF. Accesses anywhere else, including 0xBFFF, 0xE000 and the register addresses, produce neither strobe.
- R3: For a window access with address bit 12 equal to 0, `mem_addr` equals {bank register at 0xFF00, cpu_addr[11:0]}.
- R4: For a window access with address bit 12 equal to 1, `mem_addr` equals {bank register at 0xFF01, cpu_addr[11:0]}.
- R5: A write to 0xFF00 or 0xFF01 loads the 8-bit data into that bank register. A read of the same address returns the value on `cpu_rdata` in the cycle after the read strobe.
- R6: A window write asserts `mem_we` in the same cycle as `cpu_wr`, with `mem_wdata` equal to `cpu_wdata`.
- R7: A window read asserts `mem_re` in the same cycle as `cpu_rd`. In the next cycle `cpu_rdata` carries `mem_rdata`, which the memory returns one cycle after `mem_re`.
- R8: A read of an address that is neither in the window nor a bank register returns 0xFF on `cpu_rdata` in the next cycle. In a cycle that follows no read, `cpu_rdata` is 0x00.
- R9: A write to one bank register, or to any address that is not a bank register, leaves the other bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access, never asserted together with cpu_wr |
| cpu_rdata | output | 8 | Read data, valid in the cycle after cpu_rd |
| mem_addr | output | 20 | Physical video memory address |
| mem_wdata | output | 8 | Video memory write data |
| mem_we | output | 1 | Video memory write enable |
| mem_re | output | 1 | Video memory read enable |
| mem_rdata | input | 8 | Video memory read data, one cycle after mem_re |

## Verification
The assertions check the following on every cycle:
- a memory strobe never leaves the window's address range;
- the low offset bits pass straight through;
- the bank field of the physical address equals the register that address bit 12 selects;
- write data follows the processor;
- each bank register either loads the written value or holds;
- the read response in the cycle after a strobe is the memory data or the open-bus value.

Only the bench's scenarios show the following:
- the reset values of the registers;
- concrete physical addresses at the four half-window edges;
- the readback of programmed banks;
- that writes to unmapped addresses leave both registers intact, as seen through later register reads and window translations.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  // Kind of read response pending in the cycle after a processor read
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_MEM  = 2'd1,
    RSP_REG  = 2'd2,
    RSP_OPEN = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/vbm_decode.sv
module vbm_decode #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 12,
  parameter int SEL_W  = 1,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              reg_hit,
  output logic [SEL_W-1:0]  win_sel,
  output logic [SEL_W-1:0]  reg_sel
);
  localparam int TAG_LSB = OFS_W + SEL_W;

  always_comb begin
    win_hit = (addr[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB]);
    reg_hit = (addr[ADDR_W-1:SEL_W] == REG_BASE[ADDR_W-1:SEL_W]);
    win_sel = addr[TAG_LSB-1:OFS_W];
    reg_sel = addr[SEL_W-1:0];
  end
endmodule

// File: rtl/vbm_bank_regs.sv
module vbm_bank_regs #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 8,
  parameter int SEL_W     = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [BANK_W-1:0]           wr_data,
  input  logic [SEL_W-1:0]            win_sel,
  input  logic [SEL_W-1:0]            reg_sel,
  output logic [BANK_W-1:0]           win_bank,
  output logic [BANK_W-1:0]           reg_value,
  output logic [NUM_BANKS*BANK_W-1:0] bank_flat
);
  logic [BANK_W-1:0] bank_q [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    localparam logic [SEL_W-1:0] IDX = SEL_W'(i);

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[i] <= '0;
      end else if (wr_en && (wr_sel == IDX)) begin
        bank_q[i] <= wr_data;
      end
    end

    assign bank_flat[i*BANK_W +: BANK_W] = bank_q[i];

    // R5: an addressed write lands in this register
    assert_bank_load_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_sel == IDX)) |=> (bank_q[i] == $past(wr_data)));

    // R9: without an addressed write the register holds
    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_sel == IDX)) |=> $stable(bank_q[i]));
  end

  always_comb begin
    win_bank  = '0;
    reg_value = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (win_sel == SEL_W'(k)) win_bank  = bank_q[k];
      if (reg_sel == SEL_W'(k)) reg_value = bank_q[k];
    end
  end
endmodule

// File: rtl/vbm_access.sv
module vbm_access
  import vbm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 8,
  parameter int OFS_W  = 12,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [OFS_W-1:0]  cpu_ofs,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              win_hit,
  input  logic              reg_hit,
  input  logic [BANK_W-1:0] win_bank,
  input  logic [BANK_W-1:0] reg_value,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              reg_we,
  output logic [PHYS_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] cpu_rdata
);
  rsp_kind_e         rsp_q;
  logic [BANK_W-1:0] reg_q;
  logic              rd_only;

  always_comb begin
    rd_only   = cpu_rd && !cpu_wr;
    mem_we    = cpu_wr && win_hit;
    mem_re    = rd_only && win_hit;
    reg_we    = cpu_wr && reg_hit;
    mem_addr  = {win_bank, cpu_ofs};
    mem_wdata = cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= RSP_IDLE;
      reg_q <= '0;
    end else if (rd_only) begin
      reg_q <= reg_value;
      if (win_hit)      rsp_q <= RSP_MEM;
      else if (reg_hit) rsp_q <= RSP_REG;
      else              rsp_q <= RSP_OPEN;
    end else begin
      rsp_q <= RSP_IDLE;
    end
  end

  always_comb begin
    unique case (rsp_q)
      RSP_MEM:  cpu_rdata = mem_rdata;
      RSP_REG:  cpu_rdata = DATA_W'(reg_q);
      RSP_OPEN: cpu_rdata = '1;
      default:  cpu_rdata = '0;
    endcase
  end

  // R7: the cycle after a memory read strobe carries memory data
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_re) && !$past(rst)) |-> (cpu_rdata == mem_rdata));

  // R8: an unmapped read answers all ones
  assert_open_read_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_only && !win_hit && !reg_hit) && !$past(rst)) |-> (cpu_rdata == '1));
endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 8,
  parameter int OFS_W     = 12,
  parameter int NUM_BANKS = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFF00,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [PHYS_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam longint WIN_LO = longint'(WIN_BASE);
  localparam longint WIN_HI = WIN_LO + (longint'(NUM_BANKS) << OFS_W) - 1;

  logic                        win_hit;
  logic                        reg_hit;
  logic [SEL_W-1:0]            win_sel;
  logic [SEL_W-1:0]            reg_sel;
  logic [BANK_W-1:0]           win_bank;
  logic [BANK_W-1:0]           reg_value;
  logic [NUM_BANKS*BANK_W-1:0] bank_flat;
  logic                        reg_we;

  vbm_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SEL_W(SEL_W),
    .WIN_BASE(WIN_BASE), .REG_BASE(REG_BASE)
  ) u_decode (
    .addr(cpu_addr), .win_hit(win_hit), .reg_hit(reg_hit),
    .win_sel(win_sel), .reg_sel(reg_sel)
  );

  vbm_bank_regs #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SEL_W(SEL_W)
  ) u_banks (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_sel(reg_sel),
    .wr_data(cpu_wdata[BANK_W-1:0]), .win_sel(win_sel), .reg_sel(reg_sel),
    .win_bank(win_bank), .reg_value(reg_value), .bank_flat(bank_flat)
  );

  vbm_access #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .OFS_W(OFS_W)
  ) u_access (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_ofs(cpu_addr[OFS_W-1:0]), .cpu_wdata(cpu_wdata),
    .win_hit(win_hit), .reg_hit(reg_hit), .win_bank(win_bank),
    .reg_value(reg_value), .mem_rdata(mem_rdata), .reg_we(reg_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .cpu_rdata(cpu_rdata)
  );

  // R2: strobes only for addresses inside the window range
  assert_strobe_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |->
      ((longint'(cpu_addr) >= WIN_LO) && (longint'(cpu_addr) <= WIN_HI)));

  // R3: offset bits pass through untouched
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> (mem_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]));

  // R4: bank field comes from the register chosen by the half-window bit
  assert_bank_field_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |->
      (mem_addr[PHYS_W-1:OFS_W] ==
       bank_flat[cpu_addr[OFS_W+SEL_W-1:OFS_W]*BANK_W +: BANK_W]));

  // R6: write strobe and data follow the processor in the same cycle
  assert_write_follow_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (cpu_wr && (mem_wdata == cpu_wdata)));
endmodule

// File: tb/vram_bank_mapper_test.sv
module vram_bank_mapper_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Captured values of the most recent bus access
  logic        s_we, s_re;
  logic [19:0] s_addr;
  logic [7:0]  s_wdata, s_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_bank_mapper uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ {a[11:8], 4'hA};
  endfunction

  // Behavioural synchronous memory: read data one cycle after mem_re
  always @(posedge clk) if (mem_re) mem_rdata <= pat(mem_addr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    s_we = mem_we; s_re = mem_re; s_addr = mem_addr; s_wdata = mem_wdata;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    s_we = mem_we; s_re = mem_re; s_addr = mem_addr;
    @(negedge clk);
    cpu_rd = 1'b0;
    #1;
    s_rdata = cpu_rdata;
  endtask

  task automatic t_reset;
    bus_read(16'hFF00);
    check(s_rdata == 8'h00, "R1", "bank0 after reset", s_rdata, 8'h00);
    bus_read(16'hFF01);
    check(s_rdata == 8'h00, "R1", "bank1 after reset", s_rdata, 8'h00);
    @(negedge clk); #1;
    check(!mem_we && !mem_re, "R1", "idle strobes", {mem_we, mem_re}, 0);
    check(cpu_rdata == 8'h00, "R8", "idle read bus", cpu_rdata, 8'h00);
  endtask

  task automatic t_reg_rw;
    bus_write(16'hFF00, 8'h3C);
    check(!s_we, "R2", "no mem_we on register write", s_we, 0);
    bus_write(16'hFF01, 8'hA5);
    bus_read(16'hFF00);
    check(!s_re, "R2", "no mem_re on register read", s_re, 0);
    check(s_rdata == 8'h3C, "R5", "bank0 readback", s_rdata, 8'h3C);
    bus_read(16'hFF01);
    check(s_rdata == 8'hA5, "R5", "bank1 readback", s_rdata, 8'hA5);
  endtask

  task automatic t_low_window;
    bus_read(16'hC123);
    check(s_re && !s_we, "R7", "read strobe", s_re, 1);
    check(s_addr == 20'h3C123, "R3", "low half address", s_addr, 20'h3C123);
    check(s_rdata == pat(20'h3C123), "R7", "low half data", s_rdata, pat(20'h3C123));
  endtask

  task automatic t_high_window;
    bus_read(16'hD456);
    check(s_addr == 20'hA5456, "R4", "high half address", s_addr, 20'hA5456);
    check(s_rdata == pat(20'hA5456), "R7", "high half data", s_rdata, pat(20'hA5456));
  endtask

  task automatic t_write;
    bus_write(16'hC7FE, 8'h5A);
    check(s_we && !s_re, "R6", "write strobe low", s_we, 1);
    check(s_addr == 20'h3C7FE, "R3", "write address low", s_addr, 20'h3C7FE);
    check(s_wdata == 8'h5A, "R6", "write data low", s_wdata, 8'h5A);
    bus_write(16'hDABC, 8'h81);
    check(s_we, "R6", "write strobe high", s_we, 1);
    check(s_addr == 20'hA5ABC, "R4", "write address high", s_addr, 20'hA5ABC);
    check(s_wdata == 8'h81, "R6", "write data high", s_wdata, 8'h81);
  endtask

  task automatic t_bounds;
    bus_read(16'hC000);
    check(s_re && s_addr == 20'h3C000, "R3", "edge C000", s_addr, 20'h3C000);
    bus_read(16'hCFFF);
    check(s_re && s_addr == 20'h3CFFF, "R3", "edge CFFF", s_addr, 20'h3CFFF);
    bus_read(16'hD000);
    check(s_re && s_addr == 20'hA5000, "R4", "edge D000", s_addr, 20'hA5000);
    bus_read(16'hDFFF);
    check(s_re && s_addr == 20'hA5FFF, "R4", "edge DFFF", s_addr, 20'hA5FFF);
    check(s_rdata == pat(20'hA5FFF), "R7", "edge DFFF data", s_rdata, pat(20'hA5FFF));
  endtask

  task automatic t_outside;
    logic [15:0] outs [5] = '{16'hBFFF, 16'hE000, 16'h0000, 16'hFF02, 16'hFEFF};
    foreach (outs[i]) begin
      bus_write(outs[i], 8'h77);
      check(!s_we && !s_re, "R2", $sformatf("no write strobe at %h", outs[i]), s_we, 0);
      bus_read(outs[i]);
      check(!s_re && !s_we, "R2", $sformatf("no read strobe at %h", outs[i]), s_re, 0);
      check(s_rdata == 8'hFF, "R8", $sformatf("open read at %h", outs[i]), s_rdata, 8'hFF);
    end
    bus_read(16'hFF00);
    check(s_rdata == 8'h3C, "R9", "bank0 after unmapped writes", s_rdata, 8'h3C);
    bus_read(16'hFF01);
    check(s_rdata == 8'hA5, "R9", "bank1 after unmapped writes", s_rdata, 8'hA5);
  endtask

  task automatic t_indep;
    bus_write(16'hFF00, 8'h01);
    bus_read(16'hFF01);
    check(s_rdata == 8'hA5, "R9", "bank1 kept", s_rdata, 8'hA5);
    bus_read(16'hC000);
    check(s_addr == 20'h01000, "R3", "new bank0 used", s_addr, 20'h01000);
    bus_read(16'hD000);
    check(s_addr == 20'hA5000, "R9", "bank1 still used", s_addr, 20'hA5000);
    bus_write(16'hFF01, 8'hFF);
    bus_read(16'hFF00);
    check(s_rdata == 8'h01, "R9", "bank0 kept", s_rdata, 8'h01);
    bus_read(16'hDFFF);
    check(s_addr == 20'hFFFFF, "R4", "top bank top offset", s_addr, 20'hFFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reg_rw();
    t_low_window();
    t_high_window();
    t_write();
    t_bounds();
    t_outside();
    t_indep();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule